// File: doc/BRIEF.md
# Vector Integer Dot-Product Accumulate Unit

This block computes four-way integer dot products over one 128-bit vector segment. Each result lane holds the sum of four element products of the operand vectors N and M, plus the matching lane of a separate addend vector A. The result then replaces the destination. It never accumulates into it. The element size can be bytes, which produce 32-bit lanes, or halfwords, which produce 64-bit lanes. The sources can be treated as signed or unsigned.

There are two operand modes. In vector mode, each lane multiplies its own slice of M. In indexed mode, one four-element group of M is broadcast to every lane of the segment. The caller presents all operands together with a valid strobe, and the block captures the whole operand set, including all of M. One cycle later it drives the result with an output valid. An active size of 8 bytes zeroes the upper half of the result.

Top module: `dotacc_unit`

## Requirements
- R1: In byte mode (`wideElem`=0), result lane i (bits 32i+31..32i, i=0..3) equals A lane i plus the sum over k=0..3 of N byte (4i+k) times M byte (4i+k). Byte j occupies bits 8j+7..8j.
- R2: In halfword mode (`wideElem`=1), result lane i (bits 64i+63..64i, i=0..1) equals A lane i plus the sum over k=0..3 of N halfword (4i+k) times M halfword (4i+k). Every product is formed at full width before it is added.
- R3: `isSigned`=1 sign-extends every source element, and `isSigned`=0 zero-extends every source element. For example, signed bytes 0x80 times 0x80 give +16384 for each product.
- R4: The addend comes only from `vecA`. With N all zero, the result equals A within the active size, whatever earlier results were.
- R5: In indexed byte mode (`indexedMode`=1), every lane uses M bytes 4g..4g+3, where g is `groupIdx` (0..3).
- R6: In indexed halfword mode, both lanes use M halfwords 4g..4g+3, where g is `groupIdx[0]`. `groupIdx[1]` has no effect on the result.
- R7: With `fullSize`=0 (active size 8 bytes), result bits 127..64 are zero. With `fullSize`=1 (16 bytes), all lanes are computed.
- R8: Each lane sum wraps modulo 2^32 (byte mode) or 2^64 (halfword mode). There is no saturation.
- R9: A cycle with `inValid`=1 at a rising edge gives `outValid`=1 and the new `vecD` after that edge. Otherwise `outValid` is 0 and `vecD` holds its last value.
- R10: While `rstN` is low, `outValid` is 0 and `vecD` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand set valid, captured at the rising edge |
| isSigned | input | 1 | 1: signed sources and lanes, 0: unsigned |
| wideElem | input | 1 | 0: byte sources into 32-bit lanes, 1: halfword sources into 64-bit lanes |
| indexedMode | input | 1 | 1: broadcast one M group per segment |
| groupIdx | input | 2 | Selects the M group in indexed mode |
| fullSize | input | 1 | 1: 16 active bytes, 0: 8 active bytes |
| vecN | input | 128 | First source vector |
| vecM | input | 128 | Second source vector |
| vecA | input | 128 | Addend vector |
| outValid | output | 1 | Result valid for one cycle |
| vecD | output | 128 | Result vector |

## Verification
A wrong captured mode bit or group select would corrupt whole lanes in the very first result after the operation that carries it. The bench therefore compares every result vector in full against an independent model on the cycle `outValid` rises. A sign-extension fault only shows when an element has its top bit set. For that reason the extreme operands (0x80, 0xFFFF, 0x8000) are tested in every sign and size combination. A fault in the capture enable would show as `vecD` changing while `outValid` is low, so idle cycles with changing inputs are checked for a stable result.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  localparam int SEG_W      = 128;
  localparam int BYTE_W     = 8;
  localparam int HALF_W     = 16;
  localparam int TERMS      = 4;
  localparam int NARROW_W   = BYTE_W * TERMS;
  localparam int WIDE_W     = HALF_W * TERMS;
  localparam int NARROW_CNT = SEG_W / NARROW_W;
  localparam int WIDE_CNT   = SEG_W / WIDE_W;
  localparam int HALF_SEG   = SEG_W / 2;
  localparam int IDX_W      = $clog2(NARROW_CNT);

  typedef struct packed {
    logic capture;
    logic present;
  } dot_strobe_t;

  typedef struct packed {
    logic             sgn;
    logic             wide;
    logic             indexed;
    logic [IDX_W-1:0] idx;
    logic             full;
  } dot_cfg_t;
endpackage

// File: rtl/dotacc_lane.sv
module dotacc_lane #(
  parameter int ELEM_W = 8,
  parameter int LANE_W = 32,
  parameter int NTERM  = 4
) (
  input  logic                    sgn,
  input  logic [NTERM*ELEM_W-1:0] srcN,
  input  logic [NTERM*ELEM_W-1:0] srcM,
  input  logic [LANE_W-1:0]       addend,
  output logic [LANE_W-1:0]       laneSum
);
  localparam int EXT_W  = ELEM_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  logic signed [PROD_W-1:0] prod [NTERM];

  for (genvar k = 0; k < NTERM; k++) begin : g_term
    logic signed [EXT_W-1:0] extN;
    logic signed [EXT_W-1:0] extM;
    assign extN = {sgn & srcN[k*ELEM_W+ELEM_W-1], srcN[k*ELEM_W +: ELEM_W]};
    assign extM = {sgn & srcM[k*ELEM_W+ELEM_W-1], srcM[k*ELEM_W +: ELEM_W]};
    assign prod[k] = extN * extM;

    // R3: zero-extended operands never produce a negative product
    always_comb begin
      if (!sgn) begin
        a_r3_unsigned_nonneg: assert (prod[k][PROD_W-1] == 1'b0);
      end
    end
  end

  always_comb begin
    laneSum = addend;
    for (int k = 0; k < NTERM; k++) begin
      laneSum = laneSum + {{(LANE_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end
  end
endmodule

// File: rtl/dotacc_ctrl.sv
module dotacc_ctrl
  import dotacc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output dot_strobe_t strobe,
  output logic        outValid
);
  logic presentQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presentQ <= 1'b0;
    else       presentQ <= inValid;
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.present = presentQ;
  end

  assign outValid = presentQ;

  // R9: a valid strobe is answered exactly one cycle later
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/dotacc_datapath.sv
module dotacc_datapath
  import dotacc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dot_strobe_t      strobe,
  input  dot_cfg_t         cfgIn,
  input  logic [SEG_W-1:0] srcN,
  input  logic [SEG_W-1:0] srcM,
  input  logic [SEG_W-1:0] srcA,
  output logic [SEG_W-1:0] result
);
  dot_cfg_t         cfgQ;
  logic [SEG_W-1:0] nQ, mQ, aQ;

  // whole M captured with the rest, so M may alias the destination
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      nQ   <= '0;
      mQ   <= '0;
      aQ   <= '0;
    end else if (strobe.capture) begin
      cfgQ <= cfgIn;
      nQ   <= srcN;
      mQ   <= srcM;
      aQ   <= srcA;
    end
  end

  logic [NARROW_W-1:0] bcastNarrow;
  logic [WIDE_W-1:0]   bcastWide;
  assign bcastNarrow = mQ[cfgQ.idx*NARROW_W +: NARROW_W];
  assign bcastWide   = mQ[cfgQ.idx[0]*WIDE_W +: WIDE_W];

  logic [SEG_W-1:0] resNarrow, resWide;

  for (genvar i = 0; i < NARROW_CNT; i++) begin : g_narrow
    logic [NARROW_W-1:0] mSel;
    assign mSel = cfgQ.indexed ? bcastNarrow : mQ[i*NARROW_W +: NARROW_W];
    dotacc_lane #(.ELEM_W(BYTE_W), .LANE_W(NARROW_W), .NTERM(TERMS)) u_lane (
      .sgn    (cfgQ.sgn),
      .srcN   (nQ[i*NARROW_W +: NARROW_W]),
      .srcM   (mSel),
      .addend (aQ[i*NARROW_W +: NARROW_W]),
      .laneSum(resNarrow[i*NARROW_W +: NARROW_W])
    );
  end

  for (genvar i = 0; i < WIDE_CNT; i++) begin : g_wide
    logic [WIDE_W-1:0] mSel;
    assign mSel = cfgQ.indexed ? bcastWide : mQ[i*WIDE_W +: WIDE_W];
    dotacc_lane #(.ELEM_W(HALF_W), .LANE_W(WIDE_W), .NTERM(TERMS)) u_lane (
      .sgn    (cfgQ.sgn),
      .srcN   (nQ[i*WIDE_W +: WIDE_W]),
      .srcM   (mSel),
      .addend (aQ[i*WIDE_W +: WIDE_W]),
      .laneSum(resWide[i*WIDE_W +: WIDE_W])
    );
  end

  logic [SEG_W-1:0] picked;
  always_comb begin
    picked = cfgQ.wide ? resWide : resNarrow;
    result = picked;
    if (!cfgQ.full) result[SEG_W-1:HALF_SEG] = '0;
  end
endmodule

// File: rtl/dotacc_unit.sv
module dotacc_unit
  import dotacc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         isSigned,
  input  logic         wideElem,
  input  logic         indexedMode,
  input  logic [1:0]   groupIdx,
  input  logic         fullSize,
  input  logic [127:0] vecN,
  input  logic [127:0] vecM,
  input  logic [127:0] vecA,
  output logic         outValid,
  output logic [127:0] vecD
);
  dot_strobe_t strobe;
  dot_cfg_t    cfgIn;

  always_comb begin
    cfgIn.sgn     = isSigned;
    cfgIn.wide    = wideElem;
    cfgIn.indexed = indexedMode;
    cfgIn.idx     = groupIdx;
    cfgIn.full    = fullSize;
  end

  dotacc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  dotacc_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .cfgIn (cfgIn),
    .srcN  (vecN),
    .srcM  (vecM),
    .srcA  (vecA),
    .result(vecD)
  );

  // R7: short active size leaves the upper half at zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fullSize) |=> (vecD[127:64] == 64'd0));
  // R9: without a strobe the result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(vecD));
  // R4: zero N leaves exactly the addend
  a_r4_addend_only: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vecN == 128'd0) |=>
      (vecD == ($past(fullSize) ? $past(vecA) : {64'd0, $past(vecA[63:0])})));
endmodule

// File: tb/dotacc_unit_bench.sv
`timescale 1ns/1ps
module dotacc_unit_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         isSigned = 1'b0, wideElem = 1'b0, indexedMode = 1'b0, fullSize = 1'b1;
  logic [1:0]   groupIdx = 2'd0;
  logic [127:0] vecN = '0, vecM = '0, vecA = '0;
  logic         outValid;
  logic [127:0] vecD;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dotacc_unit u_dotacc_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isSigned(isSigned),
    .wideElem(wideElem), .indexedMode(indexedMode), .groupIdx(groupIdx),
    .fullSize(fullSize), .vecN(vecN), .vecM(vecM), .vecA(vecA),
    .outValid(outValid), .vecD(vecD)
  );

  // fields: sgn, wide, indexed, idx[1:0], full, seed[31:0]
  localparam logic [37:0] STIM [16] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h1234_5678},
    {1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 32'h8765_4321},
    {1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 32'hDEAD_BEEF},
    {1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 32'hCAFE_F00D},
    {1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 32'h0BAD_F00D},
    {1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 32'h1357_9BDF},
    {1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 32'h2468_ACE0},
    {1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 32'hFFFF_0001},
    {1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 32'h5555_AAAA},
    {1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 32'hA5A5_5A5A},
    {1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0F0F_F0F0},
    {1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 32'h7777_8888},
    {1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 32'h3141_5926},
    {1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 32'h2718_2818},
    {1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 32'h8080_8080},
    {1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 32'hFFFF_FFFF}
  };

  function automatic logic [127:0] spread(input logic [31:0] s);
    logic [31:0] x = s;
    logic [127:0] v;
    for (int i = 0; i < 4; i++) begin
      x = x * 32'h0019_660D + 32'h3C6E_F35F;
      v[32*i +: 32] = x;
    end
    return v;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] n, m, a,
      input logic sg, wd, ix, input logic [1:0] idx, input logic fu);
    logic [127:0] r = '0;
    logic [63:0] acc, ne, me;
    if (!wd) begin
      for (int l = 0; l < 4; l++) begin
        acc = {32'd0, a[32*l +: 32]};
        for (int k = 0; k < 4; k++) begin
          logic [7:0] nb, mb;
          nb = n[32*l + 8*k +: 8];
          mb = ix ? m[32*idx + 8*k +: 8] : m[32*l + 8*k +: 8];
          ne = sg ? {{56{nb[7]}}, nb} : {56'd0, nb};
          me = sg ? {{56{mb[7]}}, mb} : {56'd0, mb};
          acc = acc + ne * me;
        end
        r[32*l +: 32] = acc[31:0];
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        acc = a[64*l +: 64];
        for (int k = 0; k < 4; k++) begin
          logic [15:0] nh, mh;
          nh = n[64*l + 16*k +: 16];
          mh = ix ? m[64*idx[0] + 16*k +: 16] : m[64*l + 16*k +: 16];
          ne = sg ? {{48{nh[15]}}, nh} : {48'd0, nh};
          me = sg ? {{48{mh[15]}}, mh} : {48'd0, mh};
          acc = acc + ne * me;
        end
        r[64*l +: 64] = acc;
      end
    end
    if (!fu) r[127:64] = '0;
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic sg, wd, ix, input logic [1:0] idx,
      input logic fu, input logic [127:0] n, m, a);
    @(negedge clk);
    isSigned = sg; wideElem = wd; indexedMode = ix; groupIdx = idx;
    fullSize = fu; vecN = n; vecM = m; vecA = a; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic run(input string req, input logic sg, wd, ix,
      input logic [1:0] idx, input logic fu, input logic [127:0] n, m, a);
    issue(sg, wd, ix, idx, fu, n, m, a);
    check({req, " R9 valid"}, {127'd0, outValid}, 128'd1);
    check(req, vecD, model(n, m, a, sg, wd, ix, idx, fu));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] held, r1, r3;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {127'd0, outValid}, 128'd0);
    check("R10 reset data", vecD, 128'd0);
    rstN = 1'b1;

    // R1 R2 R3 R5 R6 R7 table walk
    for (int t = 0; t < 16; t++) begin
      logic [31:0] s;
      s = STIM[t][31:0];
      run("R1 R2 R3 R5 R6 R7 table", STIM[t][37], STIM[t][36], STIM[t][35],
          STIM[t][34:33], STIM[t][32], spread(s), spread(s ^ 32'hAAAA_5555),
          spread(s + 32'd1));
    end

    // R3 extreme signed byte: -128*-128*4 = 65536 per lane
    issue(1, 0, 0, 0, 1, {16{8'h80}}, {16{8'h80}}, '0);
    check("R3 signed byte extreme", vecD, {4{32'h0001_0000}});
    // R3 unsigned byte: 255*255*4
    issue(0, 0, 0, 0, 1, {16{8'hFF}}, {16{8'hFF}}, '0);
    check("R3 unsigned byte extreme", vecD, {4{32'h0003_F804}});
    // R2 unsigned halfword 65535*65535*4
    issue(0, 1, 0, 0, 1, {8{16'hFFFF}}, {8{16'hFFFF}}, '0);
    check("R2 unsigned half extreme", vecD, {2{64'h0000_0003_FFF8_0004}});
    // R2 signed halfword -32768^2*4 = 2^32
    issue(1, 1, 0, 0, 1, {8{16'h8000}}, {8{16'h8000}}, '0);
    check("R2 signed half extreme", vecD, {2{64'h0000_0001_0000_0000}});
    // R8 wrap: 0xFFFFFFFF + 4*1 -> 3
    issue(0, 0, 0, 0, 1, {16{8'h01}}, {16{8'h01}}, {4{32'hFFFF_FFFF}});
    check("R8 byte wrap", vecD, {4{32'h0000_0003}});
    issue(0, 1, 0, 0, 1, {8{16'h0001}}, {8{16'h0002}}, {2{64'hFFFF_FFFF_FFFF_FFFF}});
    check("R8 half wrap", vecD, {2{64'h0000_0000_0000_0007}});
    // R4 addend replaces destination
    issue(0, 0, 0, 0, 1, '0, spread(32'h99), spread(32'h42));
    check("R4 addend only", vecD, spread(32'h42));
    // R5 indexed byte: only group 2 nonzero
    issue(0, 0, 1, 2, 1, {16{8'h01}}, {32'd0, 32'h04030201, 64'd0}, '0);
    check("R5 indexed group 2", vecD, {4{32'd10}});
    // R6 groupIdx[1] ignored in halfword indexed mode
    issue(1, 1, 1, 1, 1, spread(32'h77), spread(32'h88), spread(32'h66));
    r1 = vecD;
    issue(1, 1, 1, 3, 1, spread(32'h77), spread(32'h88), spread(32'h66));
    r3 = vecD;
    check("R6 idx bit1 ignored", r3, r1);
    // R7 short size zeroes upper half
    issue(0, 0, 0, 0, 0, {16{8'h11}}, {16{8'h22}}, {128{1'b1}});
    check("R7 upper zero", {64'd0, vecD[127:64]}, 128'd0);
    // R9 hold while idle with changing inputs
    held = vecD;
    vecN = spread(32'h5); vecM = spread(32'h6); vecA = spread(32'h7);
    repeat (3) @(negedge clk);
    check("R9 idle valid", {127'd0, outValid}, 128'd0);
    check("R9 hold", vecD, held);
    // R10 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R10 reset again valid", {127'd0, outValid}, 128'd0);
    check("R10 reset again data", vecD, 128'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule